// File: doc/BRIEF.md
# Boot Lock Protection Checker

This block guards the program memory of a controller that reprograms itself. The memory has two parts: an application part at the low addresses and a boot part at the top. A 2-bit size setting places the boundary between them. Each part has its own 2-bit lock field. One bit of the field decides whether self-program writes may land in that part. The other bit decides whether code running in the other part may read it. On each cycle the block judges one write request and one read request against the locks, the target address and the address of the executing code. It also raises an interrupt mask when the vector table sits in a part that is closed to reads from the part now executing.

Software can only clear lock bits, and only with a command issued from the boot part. Bits go from 1 to 0 and never back. A chip-erase input is the only way to restore both fields to the open value. Write and read verdicts come out one cycle after the request. A denied write gives a one-cycle violation pulse and no write strobe, so the memory behind the block keeps its contents.

Top module: `boot_lock_guard`

## Requirements
- R1: After reset, `lock_state_o` reads 4'b1111 and `spm_ok_o`, `spm_viol_o`, `rd_ok_o` and `rd_deny_o` are all 0.
- R2: A word address is in the boot part when it is at least 2^ADDR_W − (BOOT_MIN_WORDS << (3 − sel)), where sel is `boot_size_sel_i`. So sel 3 gives the smallest boot part and sel 0 the largest. Every other address is in the application part.
- R3: If `spm_req_i` is high, the executing address is in the boot part, and bit 0 of the target part's field is 1, then `spm_ok_o` is high in the next cycle.
- R4: If `spm_req_i` is high, the executing address is in the boot part, and bit 0 of the target part's field is 0, then `spm_viol_o` pulses in the next cycle and `spm_ok_o` stays low.
- R5: A `spm_req_i` issued while the executing address is in the application part raises neither `spm_ok_o` nor `spm_viol_o`.
- R6: A read request gives `rd_ok_o` in the next cycle unless all of the following hold: the target part differs from the executing part, and bit 1 of the target part's field is 0. In that case it gives `rd_deny_o`. Exactly one of the two is high after each request.
- R7: `irq_mask_o` is high in exactly two cases. The first: `ivec_in_boot_i` is 1, the code executes from the application part, and boot field bit 1 is 0. The second: `ivec_in_boot_i` is 0, the code executes from the boot part, and application field bit 1 is 0.
- R8: `lock_state_o` is {boot field, application field}, with the application field in bits [1:0]. A `lock_prog_i` command issued from the boot part ANDs `lock_prog_data_i` (same layout) into the state in the next cycle. No bit ever goes from 0 to 1 without chip erase.
- R9: A `lock_prog_i` command issued while executing from the application part leaves `lock_state_o` unchanged.
- R10: `chip_erase_i` sets `lock_state_o` to 4'b1111 in the next cycle. It wins over a lock command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_erase_i | input | 1 | Restores both lock fields to open |
| boot_size_sel_i | input | 2 | Selects the boot part size |
| exec_addr_i | input | ADDR_W | Word address of the executing code |
| ivec_in_boot_i | input | 1 | Interrupt vectors are placed in the boot part |
| lock_prog_i | input | 1 | Lock program command |
| lock_prog_data_i | input | 4 | Lock value to AND in, {boot, app} |
| spm_req_i | input | 1 | Self-program write request |
| spm_addr_i | input | ADDR_W | Target word address of the write |
| rd_req_i | input | 1 | Program memory read request |
| rd_addr_i | input | ADDR_W | Target word address of the read |
| spm_ok_o | output | 1 | Write permitted (strobe to the array) |
| spm_viol_o | output | 1 | Write denied by a lock |
| rd_ok_o | output | 1 | Read permitted |
| rd_deny_o | output | 1 | Read denied by a lock |
| irq_mask_o | output | 1 | Interrupts must be masked |
| lock_state_o | output | 4 | Current lock fields, {boot, app} |

## Verification
The assertions assume that the size setting and the vector placement stay fixed while requests are in flight. They also assume that chip erase is a plain synchronous pulse. The stimulus keeps the size setting constant inside each phase and changes it only at phase boundaries. Chip erase and lock commands are issued at low rates, so the sticky behaviour of the locks shows over long runs. Executing addresses are drawn half from the boot part and half from the application part. The directed boundary phase puts addresses exactly on either side of each of the four boundaries.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;

  typedef enum logic {
    SEC_APP  = 1'b0,
    SEC_BOOT = 1'b1
  } section_e;

  // bit 1: open to cross-section reads, bit 0: open to self-program writes
  typedef struct packed {
    logic rd_open;
    logic wr_open;
  } lock_field_t;

  localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/section_decode.sv
module section_decode
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W         = 13,
  parameter int unsigned BOOT_MIN_WORDS = 128
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_sel_i,
  output section_e          sec_o
);

  localparam int unsigned MEM_WORDS = 1 << ADDR_W;

  logic [ADDR_W-1:0] start_tbl [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_start
    // larger select -> smaller boot part
    assign start_tbl[g] = ADDR_W'(MEM_WORDS - (BOOT_MIN_WORDS << (NUM_SIZES - 1 - g)));
  end

  assign sec_o = (addr_i >= start_tbl[size_sel_i]) ? SEC_BOOT : SEC_APP;

endmodule

// File: rtl/lock_store.sv
module lock_store
  import boot_lock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        erase_i,
  input  logic        prog_i,
  input  logic [3:0]  prog_data_i,
  output lock_field_t app_o,
  output lock_field_t boot_o
);

  lock_field_t app_q, boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q  <= '1;
      boot_q <= '1;
    end else if (erase_i) begin
      app_q  <= '1;
      boot_q <= '1;
    end else if (prog_i) begin
      // program only: 1 -> 0
      app_q  <= app_q  & lock_field_t'(prog_data_i[1:0]);
      boot_q <= boot_q & lock_field_t'(prog_data_i[3:2]);
    end
  end

  assign app_o  = app_q;
  assign boot_o = boot_q;

endmodule

// File: rtl/access_policy.sv
module access_policy
  import boot_lock_pkg::*;
(
  input  section_e    exec_sec_i,
  input  section_e    wr_sec_i,
  input  section_e    rd_sec_i,
  input  lock_field_t app_i,
  input  lock_field_t boot_i,
  input  logic        ivec_in_boot_i,
  output logic        wr_from_boot_o,
  output logic        wr_open_o,
  output logic        rd_open_o,
  output logic        irq_mask_o
);

  lock_field_t wr_fld, rd_fld;

  assign wr_fld = (wr_sec_i == SEC_BOOT) ? boot_i : app_i;
  assign rd_fld = (rd_sec_i == SEC_BOOT) ? boot_i : app_i;

  assign wr_from_boot_o = (exec_sec_i == SEC_BOOT);
  assign wr_open_o      = wr_fld.wr_open;
  assign rd_open_o      = (rd_sec_i == exec_sec_i) || rd_fld.rd_open;

  always_comb begin
    if (ivec_in_boot_i) irq_mask_o = (exec_sec_i == SEC_APP)  && !boot_i.rd_open;
    else                irq_mask_o = (exec_sec_i == SEC_BOOT) && !app_i.rd_open;
  end

endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W         = 13,
  parameter int unsigned BOOT_MIN_WORDS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_erase_i,
  input  logic [1:0]        boot_size_sel_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              ivec_in_boot_i,
  input  logic              lock_prog_i,
  input  logic [3:0]        lock_prog_data_i,
  input  logic              spm_req_i,
  input  logic [ADDR_W-1:0] spm_addr_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              spm_ok_o,
  output logic              spm_viol_o,
  output logic              rd_ok_o,
  output logic              rd_deny_o,
  output logic              irq_mask_o,
  output logic [3:0]        lock_state_o
);

  localparam int unsigned NUM_PORTS = 3;  // exec, write target, read target

  logic [ADDR_W-1:0] dec_addr [NUM_PORTS];
  section_e          dec_sec  [NUM_PORTS];

  assign dec_addr[0] = exec_addr_i;
  assign dec_addr[1] = spm_addr_i;
  assign dec_addr[2] = rd_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    section_decode #(
      .ADDR_W        (ADDR_W),
      .BOOT_MIN_WORDS(BOOT_MIN_WORDS)
    ) u_dec (
      .addr_i    (dec_addr[p]),
      .size_sel_i(boot_size_sel_i),
      .sec_o     (dec_sec[p])
    );
  end

  lock_field_t app_lk, boot_lk;
  logic        from_boot, wr_open, rd_open;

  access_policy u_policy (
    .exec_sec_i    (dec_sec[0]),
    .wr_sec_i      (dec_sec[1]),
    .rd_sec_i      (dec_sec[2]),
    .app_i         (app_lk),
    .boot_i        (boot_lk),
    .ivec_in_boot_i(ivec_in_boot_i),
    .wr_from_boot_o(from_boot),
    .wr_open_o     (wr_open),
    .rd_open_o     (rd_open),
    .irq_mask_o    (irq_mask_o)
  );

  lock_store u_locks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (chip_erase_i),
    .prog_i     (lock_prog_i && from_boot),
    .prog_data_i(lock_prog_data_i),
    .app_o      (app_lk),
    .boot_o     (boot_lk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spm_ok_o   <= 1'b0;
      spm_viol_o <= 1'b0;
      rd_ok_o    <= 1'b0;
      rd_deny_o  <= 1'b0;
    end else begin
      // commands from the application part are dropped silently
      spm_ok_o   <= spm_req_i && from_boot &&  wr_open;
      spm_viol_o <= spm_req_i && from_boot && !wr_open;
      rd_ok_o    <= rd_req_i &&  rd_open;
      rd_deny_o  <= rd_req_i && !rd_open;
    end
  end

  assign lock_state_o = {boot_lk, app_lk};

endmodule

// File: rtl/boot_lock_guard_chk.sv
module boot_lock_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chip_erase_i,
  input logic       spm_req_i,
  input logic       rd_req_i,
  input logic       spm_ok_o,
  input logic       spm_viol_o,
  input logic       rd_ok_o,
  input logic       rd_deny_o,
  input logic       irq_mask_o,
  input logic [3:0] lock_state_o
);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R10
  erase_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_i |=> (lock_state_o == 4'hF));

  // R8
  sticky_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !chip_erase_i) |=> ((lock_state_o & ~$past(lock_state_o)) == 4'h0));

  // R3
  wr_ok_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && spm_ok_o) |-> $past(spm_req_i));

  // R4
  wr_verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({spm_ok_o, spm_viol_o}));

  // R6
  rd_verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ok_o, rd_deny_o}));

  // R6
  rd_deny_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rd_deny_o) |-> $past(rd_req_i));

  // R7
  irq_mask_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o |-> (!lock_state_o[1] || !lock_state_o[3]));

endmodule

bind boot_lock_guard boot_lock_guard_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_erase_i(chip_erase_i),
  .spm_req_i   (spm_req_i),
  .rd_req_i    (rd_req_i),
  .spm_ok_o    (spm_ok_o),
  .spm_viol_o  (spm_viol_o),
  .rd_ok_o     (rd_ok_o),
  .rd_deny_o   (rd_deny_o),
  .irq_mask_o  (irq_mask_o),
  .lock_state_o(lock_state_o)
);

// File: tb/boot_lock_guard_tb_top.sv
`timescale 1ns/1ps
module boot_lock_guard_tb_top;

  localparam int AW   = 13;
  localparam int BMIN = 128;
  localparam int MEMW = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          chip_erase_i = 1'b0;
  logic [1:0]    boot_size_sel_i = 2'd0;
  logic [AW-1:0] exec_addr_i = '0;
  logic          ivec_in_boot_i = 1'b0;
  logic          lock_prog_i = 1'b0;
  logic [3:0]    lock_prog_data_i = 4'hF;
  logic          spm_req_i = 1'b0;
  logic [AW-1:0] spm_addr_i = '0;
  logic          rd_req_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic          spm_ok_o, spm_viol_o, rd_ok_o, rd_deny_o, irq_mask_o;
  logic [3:0]    lock_state_o;

  always #2 clk_i = ~clk_i;

  boot_lock_guard #(.ADDR_W(AW), .BOOT_MIN_WORDS(BMIN)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_lock = 4'hF;
  logic e_sok, e_sv, e_rok, e_rd;
  string rd_tag = "R6";

  function automatic int bstart(int sel);
    return MEMW - (BMIN << (3 - sel));
  endfunction

  function automatic logic in_boot(logic [AW-1:0] a, logic [1:0] sel);
    return int'(a) >= bstart(int'(sel));
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one clock: model the edge from the applied inputs, compare after it
  task automatic step();
    logic eb, tb_, rb_, ebn;
    logic [1:0] tf, rf, app, boot;
    @(posedge clk_i);
    eb  = in_boot(exec_addr_i, boot_size_sel_i);
    tb_ = in_boot(spm_addr_i, boot_size_sel_i);
    rb_ = in_boot(rd_addr_i, boot_size_sel_i);
    tf  = tb_ ? m_lock[3:2] : m_lock[1:0];
    rf  = rb_ ? m_lock[3:2] : m_lock[1:0];
    e_sok = spm_req_i && eb && tf[0];
    e_sv  = spm_req_i && eb && !tf[0];
    e_rok = rd_req_i && ((rb_ == eb) || rf[1]);
    e_rd  = rd_req_i && !((rb_ == eb) || rf[1]);
    if (chip_erase_i) m_lock = 4'hF;
    else if (lock_prog_i && eb) m_lock = m_lock & lock_prog_data_i;
    @(negedge clk_i);
    app  = m_lock[1:0];
    boot = m_lock[3:2];
    ebn  = in_boot(exec_addr_i, boot_size_sel_i);
    chk("R3 spm_ok", {3'b0, spm_ok_o}, {3'b0, e_sok});
    chk("R4 spm_viol", {3'b0, spm_viol_o}, {3'b0, e_sv});
    chk(rd_tag == "R2" ? "R2 rd_ok" : "R6 rd_ok", {3'b0, rd_ok_o}, {3'b0, e_rok});
    chk(rd_tag == "R2" ? "R2 rd_deny" : "R6 rd_deny", {3'b0, rd_deny_o}, {3'b0, e_rd});
    chk("R8 lock_state", lock_state_o, m_lock);
    chk("R7 irq_mask", {3'b0, irq_mask_o},
        {3'b0, ivec_in_boot_i ? (!ebn && !boot[1]) : (ebn && !app[1])});
  endtask

  function automatic logic [AW-1:0] pick_addr(logic [1:0] sel);
    if ($urandom_range(1)) return AW'($urandom_range(MEMW - 1, bstart(int'(sel))));
    return AW'($urandom_range(bstart(int'(sel)) - 1, 0));
  endfunction

  task automatic rand_inputs(int p_prog, int p_erase);
    exec_addr_i      = pick_addr(boot_size_sel_i);
    spm_addr_i       = pick_addr(boot_size_sel_i);
    rd_addr_i        = pick_addr(boot_size_sel_i);
    spm_req_i        = 1'($urandom_range(1));
    rd_req_i         = 1'($urandom_range(1));
    ivec_in_boot_i   = 1'($urandom_range(1));
    lock_prog_i      = ($urandom_range(99) < p_prog);
    lock_prog_data_i = 4'($urandom);
    chip_erase_i     = ($urandom_range(99) < p_erase);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 reset locks", lock_state_o, 4'hF);
    chk("R1 reset verdicts", {spm_ok_o, spm_viol_o, rd_ok_o, rd_deny_o}, 4'h0);

    // open locks, all verdicts pass
    for (int s = 0; s < 4; s++) begin
      boot_size_sel_i = 2'(s);
      for (int i = 0; i < 50; i++) begin rand_inputs(0, 0); step(); end
    end

    // R9: lock command from the application part is dropped
    exec_addr_i = '0; lock_prog_i = 1'b1; lock_prog_data_i = 4'h0;
    spm_req_i = 1'b0; rd_req_i = 1'b0; chip_erase_i = 1'b0;
    step();
    chk("R9 app prog ignored", lock_state_o, 4'hF);

    // R5: write request from the application part gives no verdict
    lock_prog_i = 1'b0; spm_req_i = 1'b1; spm_addr_i = '0;
    step();
    chk("R5 no verdict", {2'b0, spm_ok_o, spm_viol_o}, 4'h0);
    spm_req_i = 1'b0;

    // R2: boundary for each size, boot field closed to reads
    rd_tag = "R2";
    for (int s = 0; s < 4; s++) begin
      boot_size_sel_i = 2'(s);
      chip_erase_i = 1'b1; step(); chip_erase_i = 1'b0;
      exec_addr_i = AW'(MEMW - 1); lock_prog_i = 1'b1; lock_prog_data_i = 4'b0011;
      step(); lock_prog_i = 1'b0;
      exec_addr_i = '0; rd_req_i = 1'b1;
      rd_addr_i = AW'(bstart(s) - 1); step();
      chk("R2 below boundary", {rd_ok_o, rd_deny_o}, 2'b10);
      rd_addr_i = AW'(bstart(s)); step();
      chk("R2 at boundary", {rd_ok_o, rd_deny_o}, 2'b01);
      rd_req_i = 1'b0;
    end
    rd_tag = "R6";

    // R10: erase wins over a same-cycle lock command
    exec_addr_i = AW'(MEMW - 1); lock_prog_i = 1'b1; lock_prog_data_i = 4'h0;
    chip_erase_i = 1'b1; step();
    chk("R10 erase priority", lock_state_o, 4'hF);
    chip_erase_i = 1'b0; step();
    chk("R8 prog from boot", lock_state_o, 4'h0);
    lock_prog_i = 1'b0;

    // mixed random traffic with sticky locks and rare erases
    for (int s = 0; s < 4; s++) begin
      boot_size_sel_i = 2'(s);
      for (int i = 0; i < 1500; i++) begin rand_inputs(8, 2); step(); end
    end

    finish_run();
  end

endmodule